// File: doc/BRIEF.md
# USB Transaction Result Tracker

This block sits beside a USB host serial engine and keeps, for each of a set of endpoints, the state that the engine itself does not hold: the data toggle to use on the next data packet, a count of consecutive transaction errors, a halt flag, and the number of bytes still owed by the transfer in progress. A transfer is opened with a start strobe that gives the endpoint and the total byte count. Each SETUP, IN or OUT transaction that the engine completes is then reported to the block. The report carries the endpoint, the transaction type, the 4-bit result code and the received length, together with the endpoint's maximum packet size.

For every report the block decides whether the transfer goes on or is over. When it is over, the block raises a one-cycle finished strobe with the endpoint number and a completion status. The possible statuses are success, pipe error after a STALL, protocol error after repeated failures, or rejected SETUP. A toggle-mismatch result on IN is treated as an acknowledged duplicate: the toggle advances but the bytes are not counted. A NAK only ends a transfer when it answers a SETUP. A halted endpoint stays halted until a clear strobe for it is received.

Top module: `xrt_tracker`

## Requirements
- R1: After reset every endpoint has toggle DATA0 (tog_o bit 0), is not halted and has no transfer open, and done_o is low.
- R2: Transaction type is coded 0 = SETUP, 1 = IN, 2 = OUT. Result code 0 (success) on an open, non-halted endpoint inverts its toggle and clears its error count. Result code 1 (busy) changes no state and gives no finished strobe.
- R3: Result code 8 (toggle mismatch) on an IN transaction inverts the toggle and clears the error count, but its bytes are not subtracted from the remaining count and it never finishes the transfer.
- R4: Result code 4 (NAK) on IN or OUT leaves the toggle unchanged, clears the error count and keeps the transfer open.
- R5: NAK on SETUP finishes the transfer with status 3 (setup rejected) and does not halt the endpoint.
- R6: Result code 5 (STALL) finishes the transfer with status 1 (pipe error) and sets the endpoint's halt flag.
- R7: Codes 2, 3, 6, 7, 9, 10, 11 to 15, and code 8 on SETUP or OUT, are transaction errors. ERR_LIMIT (default 3) consecutive errors finish the transfer with status 2 (protocol error) and halt the endpoint. Any success, NAK or IN toggle mismatch in between restarts the count.
- R8: Each successful OUT consumes the smaller of the maximum packet size and the remaining bytes. The transfer finishes with status 0 once the remaining count reaches zero, so a zero-length transfer finishes on its first successful OUT. A successful SETUP consumes no bytes and does not finish.
- R9: A successful IN finishes the transfer with status 0 when its received length is below the maximum packet size, or when the remaining count reaches zero.
- R10: Results for an endpoint with no open transfer, or a halted one, are ignored. A start on a halted endpoint is ignored.
- R11: A clear strobe sets the endpoint's halt flag to 0, its toggle to DATA0 and its error count to 0, and drops any open transfer. Within a cycle, a clear takes precedence over a start, and a start takes precedence over a result for the same endpoint.
- R12: The finished strobe, its endpoint and status appear in the cycle after the result that caused them, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Open a transfer |
| start_ep_i | input | EP_W | Endpoint of the new transfer |
| start_len_i | input | LEN_W | Total bytes of the new transfer |
| res_valid_i | input | 1 | A transaction result is reported |
| res_ep_i | input | EP_W | Endpoint of the result |
| res_kind_i | input | 2 | Transaction type (0 SETUP, 1 IN, 2 OUT) |
| res_code_i | input | 4 | Engine result code |
| res_len_i | input | PKT_W | Received byte count of an IN |
| max_pkt_i | input | PKT_W | Maximum packet size of the endpoint |
| clr_i | input | 1 | Clear halt strobe |
| clr_ep_i | input | EP_W | Endpoint to clear |
| tog_o | output | NUM_EP | Next data toggle per endpoint |
| halt_o | output | NUM_EP | Halt flag per endpoint |
| done_o | output | 1 | Transfer finished strobe |
| done_ep_o | output | EP_W | Endpoint that finished |
| done_status_o | output | 2 | 0 ok, 1 pipe error, 2 protocol error, 3 setup rejected |

## Verification
A wrong toggle appears on tog_o one cycle after the result that caused it. It is also carried into every later packet, so it is checked after each exchange and not only at the end of a transfer. A wrong remaining-byte count or error count stays hidden until it moves the finished strobe. For that reason the stimulus places a toggle mismatch and interleaved NAKs just before the point where a miscounted state would finish the transfer one result early or one result late. The scoreboard then flags a strobe that is missing or comes at the wrong time.

// File: rtl/xrt_pkg.sv
package xrt_pkg;

    // transaction types
    localparam logic [1:0] KIND_SETUP = 2'd0;
    localparam logic [1:0] KIND_IN    = 2'd1;
    localparam logic [1:0] KIND_OUT   = 2'd2;

    // engine result codes
    localparam logic [3:0] RC_OK      = 4'd0;
    localparam logic [3:0] RC_BUSY    = 4'd1;
    localparam logic [3:0] RC_PKTERR  = 4'd2;
    localparam logic [3:0] RC_PIDERR  = 4'd3;
    localparam logic [3:0] RC_NAK     = 4'd4;
    localparam logic [3:0] RC_STALL   = 4'd5;
    localparam logic [3:0] RC_WRPID   = 4'd6;
    localparam logic [3:0] RC_CRCERR  = 4'd7;
    localparam logic [3:0] RC_TOGERR  = 4'd8;
    localparam logic [3:0] RC_BADLEN  = 4'd9;
    localparam logic [3:0] RC_TIMEOUT = 4'd10;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_PIPE      = 2'd1,
        ST_PROTO     = 2'd2,
        ST_SETUP_REJ = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        CL_IGNORE,
        CL_ACK,
        CL_DUP,
        CL_NAK,
        CL_STALL,
        CL_ERR
    } cls_e;

endpackage

// File: rtl/xrt_classify.sv
module xrt_classify
    import xrt_pkg::*;
(
    input  logic [3:0] code_i,
    input  logic [1:0] kind_i,
    output cls_e       cls_o
);

    always_comb begin
        case (code_i)
            RC_OK:     cls_o = CL_ACK;
            RC_BUSY:   cls_o = CL_IGNORE;
            RC_NAK:    cls_o = CL_NAK;
            RC_STALL:  cls_o = CL_STALL;
            RC_TOGERR: cls_o = (kind_i == KIND_IN) ? CL_DUP : CL_ERR;
            default:   cls_o = CL_ERR;
        endcase
    end

endmodule

// File: rtl/xrt_progress.sv
module xrt_progress
    import xrt_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int PKT_W = 7
) (
    input  logic [1:0]       kind_i,
    input  logic [LEN_W-1:0] remain_i,
    input  logic [PKT_W-1:0] rx_len_i,
    input  logic [PKT_W-1:0] max_pkt_i,
    output logic [LEN_W-1:0] remain_o,
    output logic             fin_o
);

    logic [LEN_W-1:0] rx_ext;
    logic [LEN_W-1:0] max_ext;
    logic [LEN_W-1:0] take;

    assign rx_ext  = LEN_W'(rx_len_i);
    assign max_ext = LEN_W'(max_pkt_i);

    always_comb begin
        take     = '0;
        remain_o = remain_i;
        fin_o    = 1'b0;
        if (kind_i == KIND_IN) begin
            take     = (rx_ext > remain_i) ? remain_i : rx_ext;
            remain_o = remain_i - take;
            fin_o    = (rx_len_i < max_pkt_i) || (remain_o == '0);
        end else if (kind_i == KIND_OUT) begin
            take     = (max_ext > remain_i) ? remain_i : max_ext;
            remain_o = remain_i - take;
            fin_o    = (remain_o == '0);
        end
    end

endmodule

// File: rtl/xrt_tracker.sv
module xrt_tracker
    import xrt_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int LEN_W     = 11,
    parameter int PKT_W     = 7,
    parameter int ERR_LIMIT = 3,
    localparam int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int ERR_W    = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [EP_W-1:0]   start_ep_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              res_valid_i,
    input  logic [EP_W-1:0]   res_ep_i,
    input  logic [1:0]        res_kind_i,
    input  logic [3:0]        res_code_i,
    input  logic [PKT_W-1:0]  res_len_i,
    input  logic [PKT_W-1:0]  max_pkt_i,
    input  logic              clr_i,
    input  logic [EP_W-1:0]   clr_ep_i,
    output logic [NUM_EP-1:0] tog_o,
    output logic [NUM_EP-1:0] halt_o,
    output logic              done_o,
    output logic [EP_W-1:0]   done_ep_o,
    output logic [1:0]        done_status_o
);

    typedef struct packed {
        logic             tog;
        logic             halt;
        logic             act;
        logic [ERR_W-1:0] errc;
        logic [LEN_W-1:0] remain;
    } ep_s;

    typedef struct packed {
        ep_s [NUM_EP-1:0] eps;
        logic             done;
        logic [EP_W-1:0]  done_ep;
        status_e          done_st;
    } st_s;

    st_s st_d, st_q;

    ep_s              cur;
    cls_e             cls;
    logic [LEN_W-1:0] prog_remain;
    logic             prog_fin;
    logic             start_ok;
    logic             res_take;
    logic [NUM_EP-1:0] act_w;

    assign cur = st_q.eps[res_ep_i];

    xrt_classify u_classify (
        .code_i (res_code_i),
        .kind_i (res_kind_i),
        .cls_o  (cls)
    );

    xrt_progress #(
        .LEN_W (LEN_W),
        .PKT_W (PKT_W)
    ) u_progress (
        .kind_i    (res_kind_i),
        .remain_i  (cur.remain),
        .rx_len_i  (res_len_i),
        .max_pkt_i (max_pkt_i),
        .remain_o  (prog_remain),
        .fin_o     (prog_fin)
    );

    assign start_ok = start_i && !st_q.eps[start_ep_i].halt
                      && !(clr_i && (clr_ep_i == start_ep_i));
    assign res_take = res_valid_i && cur.act && !cur.halt
                      && !(start_ok && (start_ep_i == res_ep_i))
                      && !(clr_i && (clr_ep_i == res_ep_i));

    always_comb begin
        ep_s nxt;
        st_d      = st_q;
        st_d.done = 1'b0;
        nxt       = cur;

        if (res_take) begin
            case (cls)
                CL_ACK: begin
                    nxt.tog    = ~cur.tog;
                    nxt.errc   = '0;
                    nxt.remain = prog_remain;
                    if (prog_fin) begin
                        nxt.act      = 1'b0;
                        st_d.done    = 1'b1;
                        st_d.done_st = ST_OK;
                    end
                end
                CL_DUP: begin
                    nxt.tog  = ~cur.tog;
                    nxt.errc = '0;
                end
                CL_NAK: begin
                    nxt.errc = '0;
                    if (res_kind_i == KIND_SETUP) begin
                        nxt.act      = 1'b0;
                        st_d.done    = 1'b1;
                        st_d.done_st = ST_SETUP_REJ;
                    end
                end
                CL_STALL: begin
                    nxt.act      = 1'b0;
                    nxt.halt     = 1'b1;
                    nxt.errc     = '0;
                    st_d.done    = 1'b1;
                    st_d.done_st = ST_PIPE;
                end
                CL_ERR: begin
                    if (cur.errc == ERR_W'(ERR_LIMIT - 1)) begin
                        nxt.act      = 1'b0;
                        nxt.halt     = 1'b1;
                        nxt.errc     = '0;
                        st_d.done    = 1'b1;
                        st_d.done_st = ST_PROTO;
                    end else begin
                        nxt.errc = cur.errc + ERR_W'(1);
                    end
                end
                default: begin
                end
            endcase
            st_d.eps[res_ep_i] = nxt;
            if (st_d.done) begin
                st_d.done_ep = res_ep_i;
            end
        end

        if (start_ok) begin
            st_d.eps[start_ep_i].act    = 1'b1;
            st_d.eps[start_ep_i].errc   = '0;
            st_d.eps[start_ep_i].remain = start_len_i;
        end

        if (clr_i) begin
            st_d.eps[clr_ep_i].act  = 1'b0;
            st_d.eps[clr_ep_i].halt = 1'b0;
            st_d.eps[clr_ep_i].tog  = 1'b0;
            st_d.eps[clr_ep_i].errc = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep_out
        assign tog_o[g]  = st_q.eps[g].tog;
        assign halt_o[g] = st_q.eps[g].halt;
        assign act_w[g]  = st_q.eps[g].act;
    end

    assign done_o        = st_q.done;
    assign done_ep_o     = st_q.done_ep;
    assign done_status_o = st_q.done_st;

endmodule

// File: rtl/xrt_checker.sv
module xrt_checker #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [EP_W-1:0]   start_ep_i,
    input logic              res_valid_i,
    input logic [EP_W-1:0]   res_ep_i,
    input logic [1:0]        res_kind_i,
    input logic [3:0]        res_code_i,
    input logic              clr_i,
    input logic [EP_W-1:0]   clr_ep_i,
    input logic [NUM_EP-1:0] act_w,
    input logic [NUM_EP-1:0] tog_o,
    input logic [NUM_EP-1:0] halt_o,
    input logic              done_o,
    input logic [1:0]        done_status_o
);

    logic clash;
    logic live;

    assign clash = (start_i && (start_ep_i == res_ep_i)) || (clr_i && (clr_ep_i == res_ep_i));
    assign live  = res_valid_i && act_w[res_ep_i] && !halt_o[res_ep_i] && !clash;

    AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && res_code_i == 4'd1 && !start_i && !clr_i)
        |=> (!done_o && $stable(tog_o) && $stable(halt_o))); // R2

    AST_SETUP_NAK_REJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && res_code_i == 4'd4 && res_kind_i == 2'd0)
        |=> (done_o && done_status_o == 2'd3 && !halt_o[$past(res_ep_i)])); // R5

    AST_STALL_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live && res_code_i == 4'd5)
        |=> (done_o && done_status_o == 2'd1 && halt_o[$past(res_ep_i)])); // R6

    AST_IGNORE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && !act_w[res_ep_i] && !clr_i)
        |=> !done_o); // R10

    AST_CLEAR_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!halt_o[$past(clr_ep_i)] && !tog_o[$past(clr_ep_i)])); // R11

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(res_valid_i)); // R12

endmodule

bind xrt_tracker xrt_checker #(
    .NUM_EP (NUM_EP),
    .EP_W   (EP_W)
) u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .start_ep_i    (start_ep_i),
    .res_valid_i   (res_valid_i),
    .res_ep_i      (res_ep_i),
    .res_kind_i    (res_kind_i),
    .res_code_i    (res_code_i),
    .clr_i         (clr_i),
    .clr_ep_i      (clr_ep_i),
    .act_w         (act_w),
    .tog_o         (tog_o),
    .halt_o        (halt_o),
    .done_o        (done_o),
    .done_status_o (done_status_o)
);

// File: tb/xrt_tracker_bench.sv
module xrt_tracker_bench;
    import xrt_pkg::*;

    localparam int NUM_EP = 4;
    localparam int EP_W   = 2;
    localparam int LEN_W  = 11;
    localparam int PKT_W  = 7;

    logic              clk_i = 1'b0;
    logic              rst_ni;
    logic              start_i;
    logic [EP_W-1:0]   start_ep_i;
    logic [LEN_W-1:0]  start_len_i;
    logic              res_valid_i;
    logic [EP_W-1:0]   res_ep_i;
    logic [1:0]        res_kind_i;
    logic [3:0]        res_code_i;
    logic [PKT_W-1:0]  res_len_i;
    logic [PKT_W-1:0]  max_pkt_i;
    logic              clr_i;
    logic [EP_W-1:0]   clr_ep_i;
    logic [NUM_EP-1:0] tog_o;
    logic [NUM_EP-1:0] halt_o;
    logic              done_o;
    logic [EP_W-1:0]   done_ep_o;
    logic [1:0]        done_status_o;

    always #5 clk_i = ~clk_i;

    xrt_tracker #(
        .NUM_EP (NUM_EP),
        .LEN_W  (LEN_W),
        .PKT_W  (PKT_W)
    ) u_xrt_tracker (.*);

    typedef struct {
        int    ep;
        int    st;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic exp_tog [NUM_EP];
    bit   ended = 1'b0;

    task automatic expect_done(input int ep, input int st, input string req);
        exp_t e;
        e.ep = ep; e.st = st; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a finished strobe is seen
    always @(negedge clk_i) begin
        if (rst_ni === 1'b1 && done_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R12 unexpected done actual=ep%0d/st%0d expected=none",
                         done_ep_o, done_status_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " done_ep"}, int'(done_ep_o), e.ep);
                chk({e.req, " done_status"}, int'(done_status_o), e.st);
            end
        end
    end

    task automatic start_xfer(input int ep, input int len);
        @(negedge clk_i);
        start_i     = 1'b1;
        start_ep_i  = EP_W'(ep);
        start_len_i = LEN_W'(len);
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic send(input int ep, input logic [1:0] kind, input logic [3:0] code,
                        input int len, input bit flip);
        if (flip) exp_tog[ep] = ~exp_tog[ep];
        @(negedge clk_i);
        res_valid_i = 1'b1;
        res_ep_i    = EP_W'(ep);
        res_kind_i  = kind;
        res_code_i  = code;
        res_len_i   = PKT_W'(len);
        @(negedge clk_i);
        res_valid_i = 1'b0;
    endtask

    task automatic clear_ep(input int ep);
        exp_tog[ep] = 1'b0;
        @(negedge clk_i);
        clr_i    = 1'b1;
        clr_ep_i = EP_W'(ep);
        @(negedge clk_i);
        clr_i = 1'b0;
    endtask

    task automatic chk_tog(input string req, input int ep);
        chk({req, " toggle"}, int'(tog_o[ep]), int'(exp_tog[ep]));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NUM_EP; i++) exp_tog[i] = 1'b0;
        rst_ni = 1'b0; start_i = 1'b0; start_ep_i = '0; start_len_i = '0;
        res_valid_i = 1'b0; res_ep_i = '0; res_kind_i = '0; res_code_i = '0;
        res_len_i = '0; max_pkt_i = PKT_W'(8); clr_i = 1'b0; clr_ep_i = '0;
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        chk("R1 toggles", int'(tog_o), 0);
        chk("R1 halts", int'(halt_o), 0);
        chk("R1 done", int'(done_o), 0);

        // R2 R3 R9: IN with duplicate, then short packet
        start_xfer(0, 20);
        send(0, KIND_IN, RC_OK, 8, 1);      chk_tog("R2 in ack", 0);
        send(0, KIND_IN, RC_TOGERR, 8, 1);  chk_tog("R3 dup", 0);
        send(0, KIND_IN, RC_OK, 8, 1);      // R3: 4 bytes still owed, no finish
        expect_done(0, ST_OK, "R9 short");
        send(0, KIND_IN, RC_OK, 4, 1);      chk_tog("R9 short", 0);

        // R4 R8: OUT with NAK and busy
        start_xfer(1, 16);
        send(1, KIND_OUT, RC_NAK, 0, 0);    chk_tog("R4 nak", 1);
        send(1, KIND_OUT, RC_OK, 0, 1);     chk_tog("R2 out ack", 1);
        send(1, KIND_OUT, RC_BUSY, 0, 0);   chk_tog("R2 busy", 1);
        expect_done(1, ST_OK, "R8 out");
        send(1, KIND_OUT, RC_OK, 0, 1);     chk_tog("R8 out", 1);

        // R5 SETUP NAK
        start_xfer(2, 8);
        expect_done(2, ST_SETUP_REJ, "R5 setup nak");
        send(2, KIND_SETUP, RC_NAK, 0, 0);
        chk("R5 no halt", int'(halt_o[2]), 0);

        // R7 errors with a NAK in between
        start_xfer(2, 64);
        send(2, KIND_IN, RC_CRCERR, 0, 0);
        send(2, KIND_IN, RC_TIMEOUT, 0, 0);
        send(2, KIND_IN, RC_NAK, 0, 0);
        send(2, KIND_IN, RC_PKTERR, 0, 0);
        send(2, KIND_IN, RC_PIDERR, 0, 0);
        chk("R7 not halted yet", int'(halt_o[2]), 0);
        expect_done(2, ST_PROTO, "R7 limit");
        send(2, KIND_IN, RC_BADLEN, 0, 0);
        chk("R7 halted", int'(halt_o[2]), 1);
        chk_tog("R7 errors", 2);

        // R10 halted endpoint ignores results and starts
        send(2, KIND_IN, RC_OK, 2, 0);
        chk_tog("R10 halted", 2);
        start_xfer(2, 4);
        send(2, KIND_IN, RC_OK, 0, 0);
        chk("R10 still halted", int'(halt_o[2]), 1);

        // R6 STALL then R11 clear
        start_xfer(3, 32);
        send(3, KIND_OUT, RC_OK, 0, 1);     chk_tog("R2 ep3", 3);
        expect_done(3, ST_PIPE, "R6 stall");
        send(3, KIND_OUT, RC_STALL, 0, 0);
        chk("R6 halt", int'(halt_o[3]), 1);
        clear_ep(3);
        chk("R11 halt cleared", int'(halt_o[3]), 0);
        chk_tog("R11 toggle cleared", 3);

        // R2 R8 SETUP consumes nothing, then OUT of one packet
        start_xfer(3, 8);
        send(3, KIND_SETUP, RC_OK, 0, 1);   chk_tog("R2 setup", 3);
        expect_done(3, ST_OK, "R8 after setup");
        send(3, KIND_OUT, RC_OK, 0, 1);     chk_tog("R8 after setup", 3);

        // R9 exact multiple of max packet
        start_xfer(0, 16);
        send(0, KIND_IN, RC_OK, 8, 1);
        expect_done(0, ST_OK, "R9 exact");
        send(0, KIND_IN, RC_OK, 8, 1);      chk_tog("R9 exact", 0);

        // R10 endpoint with no open transfer
        send(1, KIND_IN, RC_OK, 1, 0);      chk_tog("R10 idle", 1);

        // R8 zero-length OUT
        start_xfer(1, 0);
        expect_done(1, ST_OK, "R8 zero length");
        send(1, KIND_OUT, RC_OK, 0, 1);     chk_tog("R8 zero length", 1);

        repeat (3) @(negedge clk_i);
        chk("R12 all expected done seen", exp_q.size(), 0);
        finish_run();
    end

endmodule